// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

The block is a memory-mapped timer peripheral with a parameterised number of 32-bit down-counting channels, four by default. Software reaches it over a simple register bus: an address, write data, a write strobe, a read strobe and combinational read data. A global control register can freeze every channel at once. Each channel has a reload value, a read-only live count, a control register and a sticky timeout flag, and it drives its own interrupt line.

Once enabled, a channel counts down from its reload value. When the count passes through zero, the channel reloads and keeps running, so the timer is always periodic and software stops it by hand for single-shot use. A reload value written while the channel runs does not disturb the cycle in progress. The new value takes effect at the next expiry, or at once when the channel is turned off and on again. A reload value of all ones gives a free-running 32-bit down-counter, and the inverse of that count is a rising timestamp.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the global control register reads 0x2, with the freeze bit (bit 1) set. Every channel register reads zero and every interrupt output is low.
- R2: The global control register is at 0x000. Channel n occupies 0x100+0x10·n, with the reload value at +0x0, the live count at +0x4, control at +0x8 and the flag at +0xC. Writes to the live count are ignored. Unmapped addresses, absent channels and unused bits read as zero.
- R3: Channel control bit 0 enables the channel and bit 1 enables its interrupt. When bit 0 goes from 0 to 1, the live count takes the reload value on the following clock.
- R4: A running channel decrements by one each clock. On the clock after its count is zero, it reloads the reload value and sets its flag, so the period is reload+1 clocks. A reload value of 1 gives a period of 2.
- R5: While freeze is set, no live count changes and no flag is set.
- R6: Writing control bit 0 as zero stops the channel, and its live count then holds.
- R7: A reload value written while a channel runs leaves the current count sequence unchanged. The new value is first used at the next expiry, or on the clock after a disable/enable sequence.
- R8: Flag bit 0 is cleared by writing 1 and unaffected by writing 0. If an expiry falls in the same cycle as a clear, the flag stays set.
- R9: Each interrupt output equals the channel's flag AND its interrupt-enable bit.
- R10: Channels run independently of each other. A reload value of 0xFFFFFFFF counts down through the full 32-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe, qualifies bus_rdata |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
A wrong count or reload value shows at the live-count register on the next read, and it reaches the interrupt line within one period because the expiry moves. A stuck or lost restart request appears one clock after enable as a count that differs from the reload value. A flag that clears wrongly shows on the interrupt output in the very next cycle. The reference model therefore compares every interrupt line on every clock and every read value as soon as it is read, so that a divergence is reported within the cycle it appears.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] GLOBAL_CTL_ADDR = 12'h000;
    localparam logic [3:0] CH_REGION = 4'h1;
    localparam int FREEZE_BIT = 1;
    localparam int EN_BIT = 0;
    localparam int FLAG_BIT = 0;

    typedef enum logic [3:0] {
        SEL_RELOAD = 4'h0,
        SEL_COUNT  = 4'h4,
        SEL_CTL    = 4'h8,
        SEL_FLAG   = 4'hC
    } chan_sel_e;

    typedef struct packed {
        logic ie;
        logic en;
    } chan_ctl_t;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
        logic [3:0] sel;
    } chan_dec_t;

    function automatic chan_dec_t decode_chan(input logic [ADDR_W-1:0] a, input int unsigned n);
        chan_dec_t d;
        d.idx = a[7:4];
        d.sel = a[3:0];
        d.hit = (a[11:8] == CH_REGION) && (32'(a[7:4]) < n);
        return d;
    endfunction

endpackage

// File: rtl/tick_channel.sv
module tick_channel
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              wr_reload,
    input  logic              wr_ctl,
    input  logic              wr_flag,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] count_q,
    output chan_ctl_t         ctl_q,
    output logic              flag_q,
    output logic              irq
);

    logic restart_q;
    logic step;
    logic expire;

    assign step   = ctl_q.en && !halt && !restart_q;
    assign expire = step && (count_q == '0);
    assign irq    = flag_q && ctl_q.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q  <= '0;
            count_q   <= '0;
            ctl_q     <= '0;
            flag_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata;
            if (wr_ctl) ctl_q <= chan_ctl_t'(wdata[1:0]);
            restart_q <= wr_ctl && wdata[EN_BIT] && (restart_q || !ctl_q.en);
            if (restart_q || expire) count_q <= reload_q;
            else if (step) count_q <= count_q - DATA_W'(1);
            if (expire) flag_q <= 1'b1;
            else if (wr_flag && wdata[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    p_restart_load_r3: assert property (@(posedge clk) disable iff (rst)
        restart_q |=> count_q == $past(reload_q));

    p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
        (step && count_q != '0) |=> count_q == $past(count_q) - DATA_W'(1));

    p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count_q == $past(reload_q)) && flag_q);

    p_freeze_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (halt && !restart_q) |=> $stable(count_q));

    p_stopped_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.en && !restart_q) |=> $stable(count_q));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && wdata[FLAG_BIT] && !expire) |=> !flag_q);

endmodule

// File: rtl/tick_readback.sv
module tick_readback
    import tick_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic                           rd,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           freeze,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  reloads,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  counts,
    input  chan_ctl_t [NUM_CH-1:0]         ctls,
    input  logic [NUM_CH-1:0]              flags,
    output logic [DATA_W-1:0]              rdata
);

    chan_dec_t dec;
    assign dec = decode_chan(addr, NUM_CH);

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == GLOBAL_CTL_ADDR) begin
                rdata[FREEZE_BIT] = freeze;
            end else if (dec.hit) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (dec.idx == 4'(i)) begin
                        case (dec.sel)
                            SEL_RELOAD: rdata = reloads[i];
                            SEL_COUNT:  rdata = counts[i];
                            SEL_CTL:    rdata[1:0] = ctls[i];
                            SEL_FLAG:   rdata[FLAG_BIT] = flags[i];
                            default:    rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
    import tick_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic                          freeze_q;
    chan_dec_t                     dec;
    logic [NUM_CH-1:0][DATA_W-1:0] reloads;
    logic [NUM_CH-1:0][DATA_W-1:0] counts;
    chan_ctl_t [NUM_CH-1:0]        ctls;
    logic [NUM_CH-1:0]             flags;

    assign dec = decode_chan(bus_addr, NUM_CH);

    always_ff @(posedge clk) begin
        if (rst) freeze_q <= 1'b1;
        else if (bus_wr && bus_addr == GLOBAL_CTL_ADDR) freeze_q <= bus_wdata[FREEZE_BIT];
    end

    p_freeze_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> freeze_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit_me;
        assign hit_me = bus_wr && dec.hit && (dec.idx == 4'(g));

        tick_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .halt      (freeze_q),
            .wr_reload (hit_me && dec.sel == SEL_RELOAD),
            .wr_ctl    (hit_me && dec.sel == SEL_CTL),
            .wr_flag   (hit_me && dec.sel == SEL_FLAG),
            .wdata     (bus_wdata[DATA_W-1:0]),
            .reload_q  (reloads[g]),
            .count_q   (counts[g]),
            .ctl_q     (ctls[g]),
            .flag_q    (flags[g]),
            .irq       (irq[g])
        );
    end

    logic [DATA_W-1:0] rd_val;

    tick_readback #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rb (
        .rd      (bus_rd),
        .addr    (bus_addr),
        .freeze  (freeze_q),
        .reloads (reloads),
        .counts  (counts),
        .ctls    (ctls),
        .flags   (flags),
        .rdata   (rd_val)
    );

    assign bus_rdata = 32'(rd_val);

endmodule

// File: tb/tick_timer_top_test.sv
module tick_timer_top_test;

    localparam int NCH = 4;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    tick_timer_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    logic        m_freeze = 1'b1;
    logic [31:0] m_reload [NCH];
    logic [31:0] m_count  [NCH];
    logic        m_en     [NCH];
    logic        m_ie     [NCH];
    logic        m_flag   [NCH];
    logic        m_start  [NCH];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_freeze = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                m_reload[c] = 0; m_count[c] = 0; m_en[c] = 0;
                m_ie[c] = 0; m_flag[c] = 0; m_start[c] = 0;
            end
        end else begin
            logic old_freeze;
            old_freeze = m_freeze;
            if (bus_wr && bus_addr == 12'h000) m_freeze = bus_wdata[1];
            for (int c = 0; c < NCH; c++) begin
                logic [11:0] base;
                logic running, hit0, wr_ctl_now;
                base = 12'h100 + 12'(16 * c);
                running = m_en[c] && !old_freeze && !m_start[c];
                hit0 = running && m_count[c] == 0;
                wr_ctl_now = bus_wr && bus_addr == base + 12'h8;
                if (m_start[c] || hit0) m_count[c] = m_reload[c];
                else if (running) m_count[c] = m_count[c] - 1;
                if (hit0) m_flag[c] = 1;
                else if (bus_wr && bus_addr == base + 12'hC && bus_wdata[0]) m_flag[c] = 0;
                m_start[c] = wr_ctl_now && bus_wdata[0] && (m_start[c] || !m_en[c]);
                if (wr_ctl_now) begin
                    m_en[c] = bus_wdata[0];
                    m_ie[c] = bus_wdata[1];
                end
                if (bus_wr && bus_addr == base) m_reload[c] = bus_wdata;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h000) return {30'd0, m_freeze, 1'b0};
        for (int c = 0; c < NCH; c++) begin
            logic [11:0] base;
            base = 12'h100 + 12'(16 * c);
            if (a == base) return m_reload[c];
            if (a == base + 12'h4) return m_count[c];
            if (a == base + 12'h8) return {30'd0, m_ie[c], m_en[c]};
            if (a == base + 12'hC) return {31'd0, m_flag[c]};
        end
        return 32'd0;
    endfunction

    // R9: interrupt lines compared on every clock
    always @(negedge clk) begin
        if (!rst) begin
            logic [NCH-1:0] exp_irq;
            for (int c = 0; c < NCH; c++) exp_irq[c] = m_flag[c] && m_ie[c];
            compared++;
            if (irq !== exp_irq) begin
                mismatched++;
                $display("FAIL R9 irq: actual %b expected %b at cycle %0d", irq, exp_irq, cycles);
            end
        end
    end

    task automatic bw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [11:0] a, input string tag);
        logic [31:0] exp_v;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        exp_v = model_read(a);
        compared++;
        if (bus_rdata !== exp_v) begin
            mismatched++;
            $display("FAIL %s read 0x%03h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp_v);
        end
        bus_rd = 1'b0;
    endtask

    task automatic watch(input logic [11:0] a, input int n, input string tag);
        for (int k = 0; k < n; k++) br(a, tag);
    endtask

    initial begin : watchdog
        while (cycles < LIMIT) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        br(12'h000, "R1");
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 4; r++) br(12'h100 + 12'(16 * c + 4 * r), "R1");
        // R2 unmapped and absent channel
        br(12'h0F0, "R2");
        br(12'h140, "R2");
        br(12'h104 + 12'h001, "R2");
        // R5 freeze holds while channel 0 is armed
        bw(12'h100, 32'd5);
        bw(12'h108, 32'h3);
        watch(12'h104, 6, "R5");
        // R4 counting and reload once freeze is released
        bw(12'h000, 32'h0);
        watch(12'h104, 14, "R4");
        // R2 write to the live count is ignored
        bw(12'h104, 32'h1234);
        br(12'h104, "R2");
        // R8 writing zero keeps, writing one clears
        bw(12'h10C, 32'h0);
        br(12'h10C, "R8");
        bw(12'h10C, 32'h1);
        br(12'h10C, "R8");
        // R9 / R4 channel 1 period 2 without interrupt enable
        bw(12'h110, 32'd1);
        bw(12'h118, 32'h1);
        watch(12'h114, 6, "R4");
        br(12'h11C, "R9");
        // R8 clears racing expiries on a period-2 channel
        for (int k = 0; k < 6; k++) begin
            bw(12'h11C, 32'h1);
            br(12'h11C, "R8");
        end
        // R7 deferred reload on channel 0
        bw(12'h100, 32'd9);
        watch(12'h104, 18, "R7");
        // R6 stop and hold, then R3 restart with new value
        bw(12'h108, 32'h0);
        watch(12'h104, 4, "R6");
        bw(12'h100, 32'd3);
        bw(12'h108, 32'h3);
        watch(12'h104, 6, "R3");
        // R10 full-range free-running channel
        bw(12'h120, 32'hFFFF_FFFF);
        bw(12'h128, 32'h1);
        watch(12'h124, 5, "R10");
        // R5 freeze mid-run
        bw(12'h000, 32'h2);
        watch(12'h124, 4, "R5");
        watch(12'h104, 3, "R5");
        bw(12'h000, 32'h0);
        watch(12'h134, 2, "R10");
        watch(12'h124, 3, "R10");
        br(12'h000, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule